// File: doc/BRIEF.md
# Grouped 4-bit Weight Dequantizer

This block sits in front of a multiply-accumulate datapath. It takes a stream of 32-bit words, each carrying eight 4-bit weight codes, and turns every code into one signed fixed-point value. Weights come in groups of contiguous elements. All elements of a group share one scale and one offset.

Before any data word of a group is taken, the group's parameters arrive on their own valid/ready port. The parameter beat carries the scale, the offset, the arithmetic mode and the group length. In scale-only mode each code is a signed integer and is multiplied by the scale. In offset mode each code is an unsigned integer and goes through one fused multiply-add with the scale and the offset. Results leave one per cycle on a valid/ready stream that honours backpressure. A flag on the stream marks the final element of each group.

Top module: `grp_dequant`

## Requirements
- R1: Codes are taken from each data word starting at bits [3:0], then [7:4], and so on up to [31:28]. Each code gives exactly one output element, in that order.
- R2: With `prm_asym`=0 the code is read as two's complement (-8..7), and the output equals code × scale.
- R3: With `prm_asym`=1 the code is read as unsigned (0..15), and the output equals code × scale + offset, computed at full width with no rounding.
- R4: `prm_gsize` sets the group length: 0 gives 32 elements, 1 gives 64, and 2 or 3 give 128. `o_last` is high on the final element of each group and low on every other element.
- R5: The scale, offset, mode and length captured by one parameter beat apply to every element of that group and to no other group.
- R6: `pk_ready` stays low until the parameters of the current group have been accepted. `prm_ready` stays low while a group is still in progress.
- R7: While `o_valid` is high and `o_ready` is low, `o_valid`, `o_data` and `o_last` hold their values into the next cycle.
- R8: After reset, `o_valid` and `pk_ready` are low and `prm_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| prm_valid | input | 1 | Parameter beat valid |
| prm_ready | output | 1 | Parameter slot free |
| prm_scale | input | 16 | Group scale, signed |
| prm_zero | input | 16 | Group offset, signed (used in offset mode only) |
| prm_asym | input | 1 | 0 = scale-only mode, 1 = offset mode |
| prm_gsize | input | 2 | Group length code |
| pk_valid | input | 1 | Packed word valid |
| pk_ready | output | 1 | Packed word accepted |
| pk_data | input | 32 | Eight packed 4-bit codes |
| o_valid | output | 1 | Output element valid |
| o_ready | input | 1 | Downstream ready |
| o_data | output | 21 | Dequantized element, signed |
| o_last | output | 1 | Final element of the group |

## Verification
Some properties are checked by assertions on every cycle. These are: the held output during a stall, the rule that data is never ready while the parameter port is ready, the reset state of the output, and that the number of elements between two last flags is always a legal group length. Other behaviours can only be shown by the bench scenarios, which compare against values computed from the requirements. These are: the numeric result of each mode, the order of codes within a word, the treatment of code 3 as 128, and the switch to new parameters at a group boundary.

// File: rtl/grp_dq_pkg.sv
// Shared definitions for the grouped dequantizer.
// Assumes group length codes are fixed at two bits.
package grp_dq_pkg;
    localparam int CODE_W = 4;

    typedef enum logic [1:0] {
        GSZ_32   = 2'd0,
        GSZ_64   = 2'd1,
        GSZ_128  = 2'd2,
        GSZ_128B = 2'd3
    } gsz_e;

    // Index of the final element in a group of the given length code.
    function automatic int grp_last_idx(input gsz_e g);
        case (g)
            GSZ_32:  return 31;
            GSZ_64:  return 63;
            default: return 127;
        endcase
    endfunction
endpackage

// File: rtl/dq_param_slot.sv
// Holds one group's parameters from the accepting handshake until the
// group's last element is loaded into the output stage.
// Assumes release_i is pulsed only while held_o is high.
module dq_param_slot #(
    parameter int SW = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    output logic                 in_ready,
    input  logic signed [SW-1:0] in_scale,
    input  logic signed [SW-1:0] in_zero,
    input  logic                 in_asym,
    input  logic [1:0]           in_gsz,
    input  logic                 release_i,
    output logic                 held_o,
    output logic signed [SW-1:0] scale_o,
    output logic signed [SW-1:0] zero_o,
    output logic                 asym_o,
    output logic [1:0]           gsz_o
);
    // Slot is free only when no group is in progress.
    assign in_ready = !held_o;

    // Capture a parameter beat, or free the slot at group end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_o  <= 1'b0;
            scale_o <= '0;
            zero_o  <= '0;
            asym_o  <= 1'b0;
            gsz_o   <= 2'd0;
        end else if (in_valid && in_ready) begin
            held_o  <= 1'b1;
            scale_o <= in_scale;
            zero_o  <= in_zero;
            asym_o  <= in_asym;
            gsz_o   <= in_gsz;
        end else if (release_i) begin
            held_o  <= 1'b0;
        end
    end
endmodule

// File: rtl/dq_nibble_unpack.sv
// Buffers one packed word and presents its codes one at a time, low
// nibble first. Refuses a new word when no group is open, or when the
// element being taken closes the current group.
// Assumes group lengths are whole multiples of codes per word.
module dq_nibble_unpack #(
    parameter int WORD_W = 32,
    parameter int CODE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [WORD_W-1:0] in_data,
    input  logic              allow_i,
    input  logic              take_i,
    input  logic              grp_end_i,
    output logic              have_o,
    output logic [CODE_W-1:0] code_o
);
    localparam int NPW = WORD_W / CODE_W;
    localparam int IW  = $clog2(NPW);

    logic [WORD_W-1:0] word_q;
    logic [IW-1:0]     idx_q;
    logic              word_end;
    logic [CODE_W-1:0] lane [NPW];

    // Split the buffered word into code lanes.
    for (genvar g = 0; g < NPW; g++) begin : g_lane
        assign lane[g] = word_q[g*CODE_W +: CODE_W];
    end

    assign word_end = (idx_q == IW'(NPW - 1));
    assign code_o   = lane[idx_q];
    // Accept when a group is open and the buffer empties without ending it.
    assign in_ready = allow_i && (!have_o || (take_i && word_end && !grp_end_i));

    // Load a word or step through its codes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            idx_q  <= '0;
            have_o <= 1'b0;
        end else if (in_valid && in_ready) begin
            word_q <= in_data;
            idx_q  <= '0;
            have_o <= 1'b1;
        end else if (take_i) begin
            idx_q <= idx_q + 1'b1;
            if (word_end) have_o <= 1'b0;
        end
    end
endmodule

// File: rtl/dq_scale_fma.sv
// Converts one code to its dequantized value and registers it on the
// output stream. Scale-only mode sign-extends the code; offset mode
// zero-extends it and adds the offset in the same expression.
// Assumes OUT_W >= CODE_W + SW + 1 so no result can overflow.
module dq_scale_fma #(
    parameter int SW     = 16,
    parameter int CODE_W = 4,
    parameter int OUT_W  = 21
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    load_i,
    input  logic                    drain_i,
    input  logic [CODE_W-1:0]       code_i,
    input  logic signed [SW-1:0]    scale_i,
    input  logic signed [SW-1:0]    zero_i,
    input  logic                    asym_i,
    input  logic                    last_i,
    output logic                    space_o,
    output logic                    o_valid,
    output logic signed [OUT_W-1:0] o_data,
    output logic                    o_last
);
    logic signed [CODE_W:0]    code_x;
    logic signed [OUT_W-1:0]   prod;
    logic signed [OUT_W-1:0]   res;

    assign space_o = !o_valid || drain_i;

    // Extend code by mode, multiply, optionally add offset.
    always_comb begin
        code_x = asym_i ? $signed({1'b0, code_i}) : $signed({code_i[CODE_W-1], code_i});
        prod   = OUT_W'(code_x) * OUT_W'(scale_i);
        res    = asym_i ? prod + OUT_W'(zero_i) : prod;
    end

    // Output register with valid/ready hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_data  <= '0;
            o_last  <= 1'b0;
        end else if (load_i) begin
            o_valid <= 1'b1;
            o_data  <= res;
            o_last  <= last_i;
        end else if (drain_i) begin
            o_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/grp_dequant.sv
// Grouped 4-bit weight dequantizer top. Ties the parameter slot, the
// word unpacker and the arithmetic stage together, and counts elements
// so that the group ends after the selected length.
// Assumes one output element per cycle when downstream is ready.
module grp_dequant #(
    parameter int WORD_W  = 32,
    parameter int SCALE_W = 16,
    parameter int MAX_GRP = 128
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  prm_valid,
    output logic                  prm_ready,
    input  logic signed [SCALE_W-1:0] prm_scale,
    input  logic signed [SCALE_W-1:0] prm_zero,
    input  logic                  prm_asym,
    input  logic [1:0]            prm_gsize,
    input  logic                  pk_valid,
    output logic                  pk_ready,
    input  logic [WORD_W-1:0]     pk_data,
    output logic                  o_valid,
    input  logic                  o_ready,
    output logic signed [SCALE_W+grp_dq_pkg::CODE_W:0] o_data,
    output logic                  o_last
);
    import grp_dq_pkg::*;

    localparam int OUT_W = SCALE_W + CODE_W + 1;
    localparam int CNT_W = $clog2(MAX_GRP);

    logic                      held;
    logic signed [SCALE_W-1:0] scale_q;
    logic signed [SCALE_W-1:0] zero_q;
    logic                      asym_q;
    logic [1:0]                gsz_q;
    logic                      have;
    logic [CODE_W-1:0]         code;
    logic                      space;
    logic                      adv;
    logic                      elem_last;
    logic [CNT_W-1:0]          cnt_q;

    assign elem_last = (cnt_q == CNT_W'(grp_last_idx(gsz_e'(gsz_q))));
    assign adv       = held && have && space;

    // Element position inside the open group.
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (adv)       cnt_q <= elem_last ? '0 : cnt_q + 1'b1;
    end

    dq_param_slot #(.SW(SCALE_W)) u_slot (
        .clk(clk), .rst_n(rst_n),
        .in_valid(prm_valid), .in_ready(prm_ready),
        .in_scale(prm_scale), .in_zero(prm_zero),
        .in_asym(prm_asym), .in_gsz(prm_gsize),
        .release_i(adv && elem_last),
        .held_o(held), .scale_o(scale_q), .zero_o(zero_q),
        .asym_o(asym_q), .gsz_o(gsz_q)
    );

    dq_nibble_unpack #(.WORD_W(WORD_W), .CODE_W(CODE_W)) u_unpack (
        .clk(clk), .rst_n(rst_n),
        .in_valid(pk_valid), .in_ready(pk_ready), .in_data(pk_data),
        .allow_i(held), .take_i(adv), .grp_end_i(elem_last),
        .have_o(have), .code_o(code)
    );

    dq_scale_fma #(.SW(SCALE_W), .CODE_W(CODE_W), .OUT_W(OUT_W)) u_fma (
        .clk(clk), .rst_n(rst_n),
        .load_i(adv), .drain_i(o_ready),
        .code_i(code), .scale_i(scale_q), .zero_i(zero_q),
        .asym_i(asym_q), .last_i(elem_last),
        .space_o(space),
        .o_valid(o_valid), .o_data(o_data), .o_last(o_last)
    );
endmodule

// File: rtl/grp_dequant_chk.sv
// Protocol checker for grp_dequant, attached by bind.
// Assumes legal group lengths of 32, 64 or 128 elements.
module grp_dequant_chk #(
    parameter int OUT_W = 21
) (
    input logic             clk,
    input logic             rst_n,
    input logic             o_valid,
    input logic             o_ready,
    input logic [OUT_W-1:0] o_data,
    input logic             o_last,
    input logic             pk_ready,
    input logic             prm_ready
);
    logic [8:0] run_q;

    // Count delivered elements since the previous group end.
    always_ff @(posedge clk) begin
        if (!rst_n)                 run_q <= '0;
        else if (o_valid && o_ready) run_q <= o_last ? 9'd0 : run_q + 9'd1;
    end

    AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !o_valid && !pk_ready); // R8
    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid && !o_ready |=> o_valid && $stable(o_data) && $stable(o_last)); // R7
    AST_DATA_NEEDS_PRM: assert property (@(posedge clk) disable iff (!rst_n)
        pk_ready |-> !prm_ready); // R6
    AST_GROUP_LEN: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid && o_ready && o_last |-> (run_q == 9'd31 || run_q == 9'd63 || run_q == 9'd127)); // R4
    AST_NO_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> run_q <= 9'd127); // R4
endmodule

bind grp_dequant grp_dequant_chk #(.OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .o_valid(o_valid), .o_ready(o_ready),
    .o_data(o_data), .o_last(o_last), .pk_ready(pk_ready), .prm_ready(prm_ready)
);

// File: tb/tb_grp_dequant.sv
// Scoreboard bench: driver tasks queue expected elements, a monitor
// compares them as the design delivers.
module tb_grp_dequant;
    localparam int OUT_W = 21;

    logic        clk, rst_n;
    logic        prm_valid, prm_ready, prm_asym;
    logic signed [15:0] prm_scale, prm_zero;
    logic [1:0]  prm_gsize;
    logic        pk_valid, pk_ready;
    logic [31:0] pk_data;
    logic        o_valid, o_ready, o_last;
    logic signed [OUT_W-1:0] o_data;

    typedef struct { int data; bit last; string tag; } exp_t;
    exp_t sb[$];

    int  n_chk = 0, n_bad = 0, ready_mode = 0;
    bit  done = 0, summ = 0;
    bit  prev_stall = 0, prev_last = 0;
    int  prev_data = 0;

    grp_dequant dut (
        .clk(clk), .rst_n(rst_n),
        .prm_valid(prm_valid), .prm_ready(prm_ready),
        .prm_scale(prm_scale), .prm_zero(prm_zero),
        .prm_asym(prm_asym), .prm_gsize(prm_gsize),
        .pk_valid(pk_valid), .pk_ready(pk_ready), .pk_data(pk_data),
        .o_valid(o_valid), .o_ready(o_ready), .o_data(o_data), .o_last(o_last)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!summ) begin
            summ = 1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        end
    endtask

    // Monitor: set ready, compare elements that transfer at the next edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                check(o_valid && int'(o_data) == prev_data && o_last == prev_last,
                      "R7", int'(o_data), prev_data);
            end
            case (ready_mode)
                0:       o_ready = 1'b1;
                1:       o_ready = ($urandom_range(0, 1) == 0);
                default: o_ready = ($urandom_range(0, 3) == 0);
            endcase
            if (o_valid && o_ready) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R4", int'(o_data), 0);
                end else begin
                    exp_t e;
                    e = sb.pop_front();
                    check(int'(o_data) == e.data, e.tag, int'(o_data), e.data);
                    check(o_last == e.last, "R4", int'(o_last), int'(e.last));
                end
            end
            prev_stall = o_valid && !o_ready;
            prev_data  = int'(o_data);
            prev_last  = o_last;
        end
    end

    function automatic int expv(logic [31:0] w, int i, int scale, int zero, bit asym);
        int c;
        c = int'((w >> (4 * i)) & 32'hF);
        if (!asym && c > 7) c = c - 16;
        return c * scale + (asym ? zero : 0);
    endfunction

    task automatic send_params(int scale, int zero, bit asym, logic [1:0] gsz);
        @(negedge clk); #1;
        prm_valid = 1'b1; prm_scale = 16'(scale); prm_zero = 16'(zero);
        prm_asym = asym; prm_gsize = gsz;
        while (!prm_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        prm_valid = 1'b0;
    endtask

    task automatic send_word(logic [31:0] w, int scale, int zero, bit asym,
                             bit grp_end, string tag);
        for (int i = 0; i < 8; i++) begin
            exp_t e;
            e.data = expv(w, i, scale, zero, asym);
            e.last = grp_end && (i == 7);
            e.tag  = tag;
            sb.push_back(e);
        end
        @(negedge clk); #1;
        pk_valid = 1'b1; pk_data = w;
        while (!pk_ready) begin @(negedge clk); #1; end
        @(posedge clk); #1;
        pk_valid = 1'b0;
    endtask

    task automatic run_group(int scale, int zero, bit asym, logic [1:0] gsz,
                             logic [31:0] first_w, string tag);
        int nwords;
        nwords = (gsz == 2'd0) ? 4 : (gsz == 2'd1) ? 8 : 16;
        send_params(scale, zero, asym, gsz);
        for (int k = 0; k < nwords; k++) begin
            logic [31:0] w;
            w = (k == 0) ? first_w : $urandom;
            send_word(w, scale, zero, asym, k == nwords - 1, tag);
            if (k == 0) check(prm_ready == 1'b0, "R6", int'(prm_ready), 0);
        end
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    // Main sequence.
    initial begin
        rst_n = 0; prm_valid = 0; prm_scale = 0; prm_zero = 0; prm_asym = 0;
        prm_gsize = 0; pk_valid = 0; pk_data = 0; o_ready = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        check(o_valid == 1'b0, "R8", int'(o_valid), 0);
        check(pk_ready == 1'b0, "R8", int'(pk_ready), 0);
        check(prm_ready == 1'b1, "R8", int'(prm_ready), 1);

        // R6: data offered before any parameters is refused.
        pk_valid = 1'b1; pk_data = 32'h7654_3210;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            check(pk_ready == 1'b0, "R6", int'(pk_ready), 0);
            check(o_valid == 1'b0, "R6", int'(o_valid), 0);
        end

        ready_mode = 0;
        run_group(1, 0, 1'b0, 2'd0, 32'h7654_3210, "R1 R2");
        ready_mode = 1;
        run_group(-5, 100, 1'b1, 2'd1, 32'hFEDC_BA98, "R3");
        ready_mode = 2;
        run_group(-32768, 0, 1'b0, 2'd2, 32'h8888_8888, "R2");
        ready_mode = 1;
        run_group(7, 0, 1'b0, 2'd3, 32'h0F1E_2D3C, "R4");
        run_group(32767, 32767, 1'b1, 2'd0, 32'hFFFF_FFFF, "R3 R5");
        ready_mode = 0;
        run_group(32767, -32768, 1'b1, 2'd0, 32'h0000_0000, "R5");

        for (int t = 0; t < 3000 && sb.size() != 0; t++) @(posedge clk);
        @(negedge clk); #1;
        check(sb.size() == 0, "R4", sb.size(), 0);
        repeat (4) @(negedge clk);
        check(o_valid == 1'b0, "R4", int'(o_valid), 0);
        check(prm_ready == 1'b1, "R5", int'(prm_ready), 1);

        done = 1;
        summary();
        $finish;
    end
endmodule